// File: doc/BRIEF.md
# Calendar Second-Update and Alarm Engine

This block holds the time of day and the calendar date in binary counters and advances them once per second. A one-cycle pulse from an external 1 Hz reference starts each update. The counters step right away. The host-visible time registers are refreshed only after a fixed window of clock cycles, and an update-in-progress flag is high during that window. When the window closes, the block copies the counters out to the time registers, compares the alarm settings with the current time and sets the interrupt flags.

Control bits come in as separate input pins. These are the oscillator-mode field and the single-bit enables for hold, binary data, 24-hour mode, alarm interrupt and update-ended interrupt. The host writes time and alarm registers through a small field-select port. Decoding the host address and generating the 1 Hz reference are the job of the surrounding logic. The data-encoding and hour-format bits take effect at the next copy-out, and host writes are decoded under the encoding that is current when the write happens.

Top module: `tod_calendar_engine`

## Requirements
- R1: After reset, seconds, minutes, hours, day of week and year read 0x00, date and month read 0x01, `uip` is 0, `flagsOut` is 0x00 and `irq` is 0.
- R2: A `secTick` pulse while `oscSel` equals 3'b010 advances the time by one second. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0.
- R3: When the hour wraps, the day of week steps and wraps from 6 to 0. The date steps and returns to 1 past the month's length (30 days for months 4, 6, 9, 11; 31 for the others). Month 12 wraps to 1 and steps the two-digit year, and year 99 wraps to 00.
- R4: February has 29 days when the full year (century 20 by default, plus the two-digit year) is divisible by 4 and either not by 100 or by 400, and 28 days otherwise.
- R5: A `secTick` while `oscSel` differs from 3'b010 is ignored: no window opens and the time does not advance.
- R6: With `setMode` low, `uip` rises in the cycle after the tick and stays high for `WINDOW_CYCLES` cycles. The time outputs keep their old values during the window, then show the new time in the cycle in which `uip` falls.
- R7: With `binMode` high, time fields are plain binary. With it low, they are packed BCD (tens in bits 7:4). A change of `binMode` shows at the next copy-out.
- R8: With `hr24` high, the hour reads 0..23. With it low, it reads the hour mod 12 with bit 7 set for hours 12..23. In that mode a written hour with bit 7 set stands for its value plus 12.
- R9: While `setMode` is high, a tick does not raise `uip` and the time outputs are not refreshed, but host writes still change the registers. The fall of `setMode` reloads the counters from the registers.
- R10: The field codes of `wrSel` are 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 alarm sec, 8 alarm min, 9 alarm hour, and other codes are ignored. A write to fields 0..6 with `setMode` low reloads the counters at once, decoded under the current modes. A write while `uip` is high and `setMode` low is ignored.
- R11: An alarm field with bits 7:6 equal to 11 matches any value. Otherwise it is decoded under the current data mode and compared with the 0..23 internal hour, the minute or the second. At copy-out with `alarmEn` high, a match on all three fields sets `flagsOut` bits 7 and 5.
- R12: At each copy-out with `updEndEn` high, `flagsOut` bits 7 and 4 are set.
- R13: `flagsClr` clears `flagsOut` (bits set by a copy-out in the same cycle are kept), and `irq` follows `flagsOut` bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle 1 Hz reference pulse |
| oscSel | input | 3 | Oscillator mode field; 3'b010 means running |
| setMode | input | 1 | Hold bit: freezes copy-out and write-through |
| binMode | input | 1 | 1 = binary, 0 = BCD data |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarmEn | input | 1 | Alarm interrupt enable |
| updEndEn | input | 1 | Update-ended interrupt enable |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 4 | Field code of the write |
| wrData | input | 8 | Write data |
| flagsClr | input | 1 | Clears the flag byte |
| secOut | output | 8 | Seconds register |
| minOut | output | 8 | Minutes register |
| hourOut | output | 8 | Hours register |
| dowOut | output | 8 | Day-of-week register |
| domOut | output | 8 | Day-of-month register |
| monOut | output | 8 | Month register |
| yearOut | output | 8 | Two-digit year register |
| uip | output | 1 | Update in progress |
| flagsOut | output | 8 | Interrupt flag byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that `uip` is never high outside an open window and that it falls after each window. They also check that ignored ticks open no window, that a set hold bit keeps every register stable, that the time outputs cannot change inside a window, and that an enabled update-ended event always lands in the flag byte. The calendar arithmetic can only be shown by the bench scenarios, which set exact values and compare the copied-out bytes. This covers year and month rollover, leap and non-leap Februaries, 30-day months, BCD against binary encoding, both hour formats, wildcard and non-wildcard alarms, and the reload when the hold bit is cleared.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 10;
  localparam int TIME_FIELDS = 7;

  localparam logic [3:0] F_SEC   = 4'd0;
  localparam logic [3:0] F_MIN   = 4'd1;
  localparam logic [3:0] F_HOUR  = 4'd2;
  localparam logic [3:0] F_DOW   = 4'd3;
  localparam logic [3:0] F_DOM   = 4'd4;
  localparam logic [3:0] F_MON   = 4'd5;
  localparam logic [3:0] F_YEAR  = 4'd6;
  localparam logic [3:0] F_ASEC  = 4'd7;
  localparam logic [3:0] F_AMIN  = 4'd8;
  localparam logic [3:0] F_AHOUR = 4'd9;

  localparam logic [2:0] OSC_RUN_CODE = 3'b010;

  typedef struct packed {
    logic advance;   // step the counters by one second
    logic finish;    // close the window: copy out, compare, flag
    logic reload;    // load counters from the register images
    logic wrAccept;  // host write goes into the images
  } todStrobe_t;

  function automatic logic [BYTE_W-1:0] decodeVal(input logic [BYTE_W-1:0] v, input logic bin);
    logic [BYTE_W-1:0] tens;
    tens = {4'd0, v[7:4]};
    return bin ? v : (tens * 8'd10 + {4'd0, v[3:0]});
  endfunction

  function automatic logic [BYTE_W-1:0] encodeVal(input logic [BYTE_W-1:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 8'd10);
    ones = 4'(v % 8'd10);
    return bin ? v : {tens, ones};
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int WINDOW_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [2:0] oscSel,
  input  logic       setMode,
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  output todStrobe_t strb,
  output logic       uip
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);

  logic             busy;
  logic [CNT_W-1:0] winCnt;
  logic             prevSet;
  logic             oscOk;
  logic             fieldOk;
  logic             timeField;
  logic             accepted;

  assign oscOk     = (oscSel == OSC_RUN_CODE);
  assign fieldOk   = (wrSel <= F_AHOUR);
  assign timeField = (wrSel <= F_YEAR);
  assign accepted  = wrEn && fieldOk && (!uip || setMode);

  always_comb begin
    strb          = '0;
    strb.advance  = secTick && oscOk && !busy;
    strb.finish   = busy && (winCnt == '0);
    strb.wrAccept = accepted;
    strb.reload   = (accepted && timeField && !setMode) || (prevSet && !setMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      winCnt  <= '0;
      uip     <= 1'b0;
      prevSet <= 1'b0;
    end else begin
      prevSet <= setMode;
      if (strb.advance) begin
        busy   <= 1'b1;
        winCnt <= CNT_W'(WINDOW_CYCLES - 1);
        uip    <= !setMode;
      end else if (busy) begin
        if (winCnt == '0) begin
          busy <= 1'b0;
          uip  <= 1'b0;
        end else begin
          winCnt <= winCnt - 1'b1;
        end
      end
      if (setMode) uip <= 1'b0;
    end
  end

  AST_UIP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    uip |-> busy); // R6
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !uip); // R6
  AST_OSC_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !oscOk && !busy) |=> !busy); // R5
  AST_HOLD_NO_UIP: assert property (@(posedge clk) disable iff (!rstN)
    setMode |=> !uip); // R9
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int CENTURY = 20
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  todStrobe_t                            strb,
  input  logic                                  setMode,
  input  logic                                  binMode,
  input  logic                                  hr24,
  input  logic                                  alarmEn,
  input  logic                                  updEndEn,
  input  logic [3:0]                            wrSel,
  input  logic [BYTE_W-1:0]                     wrData,
  input  logic                                  flagsClr,
  output logic [TIME_FIELDS-1:0][BYTE_W-1:0]    timeImg,
  output logic [BYTE_W-1:0]                     flags
);
  localparam logic CENTURY_LEAP = ((CENTURY % 4) == 0);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] imgQ;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] imgNext;

  logic [BYTE_W-1:0] secC, minC, hourC, dowC, domC, monC, yearC;
  logic [BYTE_W-1:0] secN, minN, hourN, dowN, domN, monN, yearN;
  logic [BYTE_W-1:0] hourLd;
  logic [BYTE_W-1:0] daysInMon;
  logic              leapYear;
  logic              almHit;
  logic [BYTE_W-1:0] hourEnc;
  logic [BYTE_W-1:0] flagsNext;

  // images after the host write of this cycle
  always_comb begin
    imgNext = imgQ;
    if (strb.wrAccept) imgNext[wrSel] = wrData;
  end

  // hour reload: 12-hour mode adds 12 for the PM bit
  always_comb begin
    hourLd = decodeVal({1'b0, imgNext[F_HOUR][6:0]}, binMode);
    if (!hr24 && imgNext[F_HOUR][7]) hourLd = hourLd + 8'd12;
  end

  assign leapYear = (yearC[1:0] == 2'b00) && ((yearC != 8'd0) || CENTURY_LEAP);

  always_comb begin
    case (monC)
      8'd2:                     daysInMon = leapYear ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  daysInMon = 8'd30;
      default:                  daysInMon = 8'd31;
    endcase
  end

  // one-second step of the counters
  always_comb begin
    secN = secC; minN = minC; hourN = hourC; dowN = dowC;
    domN = domC; monN = monC; yearN = yearC;
    secN = secC + 8'd1;
    if (secN >= 8'd60) begin
      secN = 8'd0;
      minN = minC + 8'd1;
      if (minN >= 8'd60) begin
        minN  = 8'd0;
        hourN = hourC + 8'd1;
        if (hourN >= 8'd24) begin
          hourN = 8'd0;
          dowN  = (dowC >= 8'd6) ? 8'd0 : dowC + 8'd1;
          domN  = domC + 8'd1;
          if (domN == 8'd0) begin
            domN = 8'd1;
          end else if (domN > daysInMon) begin
            domN = 8'd1;
            monN = monC + 8'd1;
            if (monN > 8'd12) begin
              monN  = 8'd1;
              yearN = (yearC >= 8'd99) ? 8'd0 : yearC + 8'd1;
            end
          end
        end
      end
    end
  end

  // alarm compare against the live counters
  always_comb begin
    logic sOk, mOk, hOk;
    sOk = (imgQ[F_ASEC][7:6]  == 2'b11) || (decodeVal(imgQ[F_ASEC],  binMode) == secC);
    mOk = (imgQ[F_AMIN][7:6]  == 2'b11) || (decodeVal(imgQ[F_AMIN],  binMode) == minC);
    hOk = (imgQ[F_AHOUR][7:6] == 2'b11) || (decodeVal(imgQ[F_AHOUR], binMode) == hourC);
    almHit = sOk && mOk && hOk;
  end

  always_comb begin
    if (hr24) hourEnc = encodeVal(hourC, binMode);
    else      hourEnc = encodeVal(8'(hourC % 8'd12), binMode) | ((hourC >= 8'd12) ? 8'h80 : 8'h00);
  end

  always_comb begin
    flagsNext = flagsClr ? 8'h00 : flags;
    if (strb.finish) begin
      if (alarmEn && almHit) flagsNext = flagsNext | 8'hA0;
      if (updEndEn)          flagsNext = flagsNext | 8'h90;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secC <= '0; minC <= '0; hourC <= '0; dowC <= '0;
      domC <= 8'd1; monC <= 8'd1; yearC <= '0;
    end else if (strb.reload) begin
      secC  <= decodeVal(imgNext[F_SEC], binMode);
      minC  <= decodeVal(imgNext[F_MIN], binMode);
      hourC <= hourLd;
      dowC  <= decodeVal(imgNext[F_DOW], binMode);
      domC  <= decodeVal(imgNext[F_DOM], binMode);
      monC  <= decodeVal(imgNext[F_MON], binMode);
      yearC <= decodeVal(imgNext[F_YEAR], binMode);
    end else if (strb.advance) begin
      secC <= secN; minC <= minN; hourC <= hourN; dowC <= dowN;
      domC <= domN; monC <= monN; yearC <= yearN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FIELDS; i++) imgQ[i] <= '0;
      imgQ[F_DOM] <= 8'h01;
      imgQ[F_MON] <= 8'h01;
      flags       <= '0;
    end else begin
      imgQ <= imgNext;
      if (strb.finish && !setMode) begin
        imgQ[F_SEC]  <= encodeVal(secC, binMode);
        imgQ[F_MIN]  <= encodeVal(minC, binMode);
        imgQ[F_HOUR] <= hourEnc;
        imgQ[F_DOW]  <= encodeVal(dowC, binMode);
        imgQ[F_DOM]  <= encodeVal(domC, binMode);
        imgQ[F_MON]  <= encodeVal(monC, binMode);
        imgQ[F_YEAR] <= encodeVal(yearC, binMode);
      end
      flags <= flagsNext;
    end
  end

  for (genvar g = 0; g < TIME_FIELDS; g++) begin : g_out
    assign timeImg[g] = imgQ[g];
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.reload) |=> (secC < 8'd60)); // R2
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.reload) |=> (hourC < 8'd24)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (setMode && !strb.wrAccept) |=> $stable(imgQ)); // R9
  AST_UPDEND_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && updEndEn) |=> (flags[7] && flags[4])); // R12
endmodule

// File: rtl/tod_calendar_engine.sv
module tod_calendar_engine
  import tod_pkg::*;
#(
  parameter int WINDOW_CYCLES = 8,
  parameter int CENTURY       = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [2:0] oscSel,
  input  logic       setMode,
  input  logic       binMode,
  input  logic       hr24,
  input  logic       alarmEn,
  input  logic       updEndEn,
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       flagsClr,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] domOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic       uip,
  output logic [7:0] flagsOut,
  output logic       irq
);
  todStrobe_t                          strb;
  logic [TIME_FIELDS-1:0][BYTE_W-1:0]  timeImg;

  tod_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .oscSel(oscSel),
    .setMode(setMode), .wrEn(wrEn), .wrSel(wrSel),
    .strb(strb), .uip(uip)
  );

  tod_datapath #(.CENTURY(CENTURY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .setMode(setMode),
    .binMode(binMode), .hr24(hr24), .alarmEn(alarmEn), .updEndEn(updEndEn),
    .wrSel(wrSel), .wrData(wrData), .flagsClr(flagsClr),
    .timeImg(timeImg), .flags(flagsOut)
  );

  assign secOut  = timeImg[F_SEC];
  assign minOut  = timeImg[F_MIN];
  assign hourOut = timeImg[F_HOUR];
  assign dowOut  = timeImg[F_DOW];
  assign domOut  = timeImg[F_DOM];
  assign monOut  = timeImg[F_MON];
  assign yearOut = timeImg[F_YEAR];
  assign irq     = flagsOut[7];

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (uip && !strb.finish) |=> $stable({secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut})); // R6 R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (flagsClr && !strb.finish) |=> !irq); // R13
endmodule

// File: tb/tod_calendar_engine_tb.sv
module tod_calendar_engine_tb_top;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [2:0] oscSel = 3'b010;
  logic setMode = 1'b0, binMode = 1'b0, hr24 = 1'b1, alarmEn = 1'b0, updEndEn = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrSel = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic flagsClr = 1'b0;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut, flagsOut;
  logic uip, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_calendar_engine #(.WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .oscSel(oscSel),
    .setMode(setMode), .binMode(binMode), .hr24(hr24), .alarmEn(alarmEn),
    .updEndEn(updEndEn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .flagsClr(flagsClr), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dowOut(dowOut), .domOut(domOut), .monOut(monOut), .yearOut(yearOut),
    .uip(uip), .flagsOut(flagsOut), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic clr();
    @(negedge clk); flagsClr = 1'b1;
    @(negedge clk); flagsClr = 1'b0;
  endtask

  // full tick: returns after the window closed
  task automatic tick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (WIN) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 sec", secOut, 8'h00);   chk("R1 min", minOut, 8'h00);
    chk("R1 hour", hourOut, 8'h00); chk("R1 dow", dowOut, 8'h00);
    chk("R1 dom", domOut, 8'h01);   chk("R1 mon", monOut, 8'h01);
    chk("R1 year", yearOut, 8'h00); chk("R1 uip", {7'd0, uip}, 8'h00);
    chk("R1 flags", flagsOut, 8'h00); chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_rollover();
    wr(4'd6, 8'h99); wr(4'd5, 8'h12); wr(4'd4, 8'h31); wr(4'd3, 8'h06);
    setTime(8'h23, 8'h59, 8'h59);
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk("R6 uip raised", {7'd0, uip}, 8'h01);
    repeat (WIN - 1) @(negedge clk);
    chk("R6 uip late window", {7'd0, uip}, 8'h01);
    chk("R6 sec held in window", secOut, 8'h59);
    @(negedge clk);
    chk("R6 uip cleared", {7'd0, uip}, 8'h00);
    chk("R2 sec wrap", secOut, 8'h00); chk("R2 min wrap", minOut, 8'h00);
    chk("R2 hour wrap", hourOut, 8'h00); chk("R3 dow wrap", dowOut, 8'h00);
    chk("R3 dom wrap", domOut, 8'h01); chk("R3 mon wrap", monOut, 8'h01);
    chk("R3 year wrap", yearOut, 8'h00);
  endtask

  task automatic test_leap();
    wr(4'd6, 8'h00); wr(4'd5, 8'h02); wr(4'd4, 8'h28); setTime(8'h23, 8'h59, 8'h59);
    tick();
    chk("R4 2000 feb29 dom", domOut, 8'h29); chk("R4 2000 feb29 mon", monOut, 8'h02);
    setTime(8'h23, 8'h59, 8'h59); tick();
    chk("R4 2000 mar1 dom", domOut, 8'h01); chk("R4 2000 mar1 mon", monOut, 8'h03);
    wr(4'd6, 8'h01); wr(4'd5, 8'h02); wr(4'd4, 8'h28); setTime(8'h23, 8'h59, 8'h59);
    tick();
    chk("R4 2001 dom", domOut, 8'h01); chk("R4 2001 mon", monOut, 8'h03);
    wr(4'd6, 8'h24); wr(4'd5, 8'h02); wr(4'd4, 8'h28); setTime(8'h23, 8'h59, 8'h59);
    tick();
    chk("R4 2024 dom", domOut, 8'h29);
    wr(4'd5, 8'h04); wr(4'd4, 8'h30); setTime(8'h23, 8'h59, 8'h59);
    tick();
    chk("R3 30-day dom", domOut, 8'h01); chk("R3 30-day mon", monOut, 8'h05);
  endtask

  task automatic test_binary();
    binMode = 1'b1;
    setTime(8'd0, 8'd0, 8'd32);
    tick();
    chk("R7 binary sec", secOut, 8'd33);
    binMode = 1'b0;
    tick();
    chk("R7 bcd after switch", secOut, 8'h34);
    chk("R7 bcd min", minOut, 8'h00);
  endtask

  task automatic test_hours();
    setTime(8'h13, 8'h00, 8'h00);
    hr24 = 1'b0;
    tick();
    chk("R8 12h pm hour", hourOut, 8'h81);
    chk("R8 sec", secOut, 8'h01);
    setTime(8'h91, 8'h59, 8'h59);
    tick();
    chk("R8 12h midnight", hourOut, 8'h00);
    chk("R8 min wrap", minOut, 8'h00);
    hr24 = 1'b1;
  endtask

  task automatic test_osc();
    wr(4'd0, 8'h10);
    oscSel = 3'b000;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk("R5 no uip", {7'd0, uip}, 8'h00);
    repeat (WIN) @(negedge clk);
    chk("R5 sec unchanged", secOut, 8'h10);
    oscSel = 3'b010;
    tick();
    chk("R5 no hidden advance", secOut, 8'h11);
  endtask

  task automatic test_hold();
    wr(4'd0, 8'h20);
    setMode = 1'b1;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk("R9 no uip", {7'd0, uip}, 8'h00);
    repeat (WIN) @(negedge clk);
    chk("R9 not refreshed", secOut, 8'h20);
    wr(4'd0, 8'h40);
    chk("R9 write in hold", secOut, 8'h40);
    @(negedge clk); setMode = 1'b0;
    tick();
    chk("R9 reload on release", secOut, 8'h41);
  endtask

  task automatic test_blocked();
    wr(4'd0, 8'h05);
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    wrEn = 1'b1; wrSel = 4'd0; wrData = 8'h50;
    @(negedge clk); wrEn = 1'b0;
    repeat (WIN - 1) @(negedge clk);
    chk("R10 write in window ignored", secOut, 8'h06);
    tick();
    chk("R10 counter untouched", secOut, 8'h07);
    wr(4'd12, 8'h33);
    chk("R10 bad field ignored", secOut, 8'h07);
  endtask

  task automatic test_alarm();
    setTime(8'h10, 8'h00, 8'h04);
    wr(4'd7, 8'h05); wr(4'd8, 8'hC0); wr(4'd9, 8'hFF);
    alarmEn = 1'b1; clr();
    tick();
    chk("R11 wildcard match", flagsOut, 8'hA0);
    chk("R13 irq", {7'd0, irq}, 8'h01);
    clr();
    chk("R13 cleared", flagsOut, 8'h00);
    chk("R13 irq low", {7'd0, irq}, 8'h00);
    wr(4'd7, 8'h30); tick();
    chk("R11 sec mismatch", flagsOut, 8'h00);
    wr(4'd7, 8'h07); wr(4'd9, 8'h05); tick();
    chk("R11 hour mismatch", flagsOut, 8'h00);
    wr(4'd9, 8'h10); wr(4'd7, 8'h08); wr(4'd8, 8'h00); tick();
    chk("R11 full match", flagsOut, 8'hA0);
    clr();
    alarmEn = 1'b0; wr(4'd7, 8'h09); tick();
    chk("R11 disabled", flagsOut, 8'h00);
  endtask

  task automatic test_updend();
    updEndEn = 1'b1; clr(); tick();
    chk("R12 update ended", flagsOut, 8'h90);
    alarmEn = 1'b1; wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0); clr();
    tick();
    chk("R12 with alarm", flagsOut, 8'hB0);
    alarmEn = 1'b0; updEndEn = 1'b0; clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_rollover();
    test_leap();
    test_binary();
    test_hours();
    test_osc();
    test_hold();
    test_blocked();
    test_alarm();
    test_updend();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule